// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block runs one asynchronous read or write at a time to an external NOR flash, SRAM or PSRAM device. It splits each access into timed phases and counts each phase in system clock cycles. The phases are address setup, address hold (used only when address and data share pins), data setup, a one-cycle write recovery (writes only) and a bus turnaround gap. The request and all timing settings are captured when the request is accepted. Settings that change while an access runs have no effect on that access.

The request address is split into two parts. The low bits form an offset inside a fixed 64-Mbyte window and drive the memory address bus. The bits above the offset pick one of several active-low chip selects, one per window. Read data is taken from the data bus on the last data setup cycle and is returned with a one-cycle done pulse. A ready output is low from acceptance until the sequencer is idle again, which holds off new requests.

The controller has six states: `ST_IDLE`, `ST_ADDR_SETUP`, `ST_ADDR_HOLD`, `ST_DATA_SETUP`, `ST_WRITE_RECOV` and `ST_TURNAROUND`. Its transitions are:
- idle→addr-setup on accept with a nonzero setup length.
- idle→addr-hold on accept with zero setup in multiplexed mode.
- idle→data-setup on accept with zero setup in demultiplexed mode.
- addr-setup→addr-hold (multiplexed) or addr-setup→data-setup (demultiplexed) when the setup count expires.
- addr-hold→data-setup when the hold count expires.
- data-setup→write-recov for writes. For reads, data-setup goes to turnaround or to idle, depending on whether the turnaround length is nonzero.
- write-recov→turnaround or write-recov→idle, chosen the same way.
- turnaround→idle when the gap count expires.

Top module: `sas_async_seq`

## Requirements
- R1: After reset the sequencer is idle. Ready is high, all chip selects, output enable and write enable are high (inactive), the data bus is not driven and done is low.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. Address, direction, write data and all four timing settings, plus the multiplexed-mode flag, are captured at that edge. Later changes to these inputs do not alter the running access.
- R3: Address bits [ADDR_W-1:26] select exactly one of the 2^(ADDR_W-26) active-low chip selects, with bit i of mem_cs_n serving window i. mem_addr carries address bits [25:0]. Both hold steady for the whole access.
- R4: The address setup phase lasts cfg_addr_setup cycles (0 to 15). A value of 0 skips the phase.
- R5: In multiplexed mode (cfg_muxed=1) an address hold phase of cfg_addr_hold cycles follows, and a setting of 0 is treated as 1. During address setup and address hold, mem_dq_out drives address bits [DATA_W-1:0] with mem_dq_oe high. In demultiplexed mode there is no hold phase.
- R6: The data setup phase lasts cfg_data_setup cycles. A setting of 0 is treated as 1, and a setting above 256 is treated as 256.
- R7: For a read, mem_oe_n is low for exactly the data setup cycles and the data bus is not driven. rdata equals mem_dq_in from the last data setup cycle, and done is high for one cycle, the one right after that data setup cycle.
- R8: For a write, mem_we_n is low for exactly the data setup cycles. One write recovery cycle follows with the chip select still low and mem_we_n high. mem_dq_out carries the write data with mem_dq_oe high in both. done follows the last data setup cycle as for reads.
- R9: After the access, a turnaround gap of cfg_addr_turnaround cycles (0 to 15) follows. During the gap all strobes are high and ready stays low.
- R10: req_ready is low from the cycle after acceptance until the sequencer returns to idle. Requests presented in that time are ignored and start no access.
- R11: At most one chip select is low at any time, and output enable and write enable are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all phase lengths count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | High when idle and able to accept |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; upper bits select the window |
| req_wdata | input | DATA_W | Write data |
| cfg_muxed | input | 1 | Address and data share the data bus |
| cfg_addr_setup | input | 4 | Address setup length in cycles |
| cfg_addr_hold | input | 4 | Address hold length in cycles (multiplexed mode) |
| cfg_data_setup | input | 9 | Data setup length in cycles, clamped to 1..256 |
| cfg_addr_turnaround | input | 4 | Turnaround gap in cycles |
| mem_cs_n | output | 2^(ADDR_W-26) | Active-low chip select per window |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | 26 | Offset within the window |
| mem_dq_out | output | DATA_W | Data bus value driven toward memory |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | DATA_W | Data bus value read from memory |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read data, valid with done |

## Verification
All strobe, bus and ready outputs depend only on the state register. They therefore change one edge after acceptance or after a phase expires. Once an access is accepted, the bench can compute for every later cycle k which phase is due: setup, then hold, then data setup, then recovery, then turnaround. It compares every output at the falling edge of that cycle. done and rdata pass through one more register. They are expected in cycle setup+hold+data+1, and rdata must match the mem_dq_in value the bench drove in cycle setup+hold+data. While an access runs, the bench keeps presenting junk requests and configuration. The idle cycle after the expected end must then show no new chip select.

// File: rtl/sas_pkg.sv
package sas_pkg;

    localparam int SAS_SET_W = 4;    // setup, hold and turnaround fields
    localparam int SAS_DST_W = 9;    // data setup field, 0..511 before clamping
    localparam int SAS_CNT_W = 8;    // phase counter, longest phase is 256 cycles
    localparam int SAS_DST_MAX = 256;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_ADDR_SETUP  = 3'd1,
        ST_ADDR_HOLD   = 3'd2,
        ST_DATA_SETUP  = 3'd3,
        ST_WRITE_RECOV = 3'd4,
        ST_TURNAROUND  = 3'd5
    } sas_state_e;

    typedef struct packed {
        logic                 muxed;
        logic [SAS_SET_W-1:0] setup_len;
        logic [SAS_SET_W-1:0] hold_len;
        logic [SAS_DST_W-1:0] data_len;
        logic [SAS_SET_W-1:0] turn_len;
    } sas_timing_t;

endpackage

// File: rtl/sas_cfg_clamp.sv
module sas_cfg_clamp
    import sas_pkg::*;
(
    input  logic                 muxed,
    input  logic [SAS_SET_W-1:0] addr_setup,
    input  logic [SAS_SET_W-1:0] addr_hold,
    input  logic [SAS_DST_W-1:0] data_setup,
    input  logic [SAS_SET_W-1:0] turnaround,
    output sas_timing_t          timing
);

    localparam logic [SAS_DST_W-1:0] DST_HI = SAS_DST_W'(SAS_DST_MAX);
    localparam logic [SAS_DST_W-1:0] DST_LO = SAS_DST_W'(1);

    always_comb begin
        timing.muxed     = muxed;
        timing.setup_len = addr_setup;
        timing.turn_len  = turnaround;

        if (addr_hold == '0) begin
            timing.hold_len = SAS_SET_W'(1);
        end else begin
            timing.hold_len = addr_hold;
        end

        if (data_setup == '0) begin
            timing.data_len = DST_LO;
        end else if (data_setup > DST_HI) begin
            timing.data_len = DST_HI;
        end else begin
            timing.data_len = data_setup;
        end
    end

endmodule

// File: rtl/sas_phase_timer.sv
module sas_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sas_bank_decode.sv
module sas_bank_decode #(
    parameter int ADDR_W = 28,
    parameter int WIN_W  = 26,
    localparam int BANK_W = ADDR_W - WIN_W,
    localparam int BANKS  = 1 << BANK_W
) (
    input  logic              enable,
    input  logic [ADDR_W-1:0] addr,
    output logic [BANKS-1:0]  cs_n
);

    logic [BANK_W-1:0] bank_idx;

    assign bank_idx = addr[ADDR_W-1:WIN_W];

    for (genvar g = 0; g < BANKS; g++) begin : g_cs
        assign cs_n[g] = !(enable && (bank_idx == BANK_W'(g)));
    end

endmodule

// File: rtl/sas_async_seq.sv
module sas_async_seq
    import sas_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int WIN_W  = 26,
    parameter int DATA_W = 16,
    localparam int BANK_W = ADDR_W - WIN_W,
    localparam int BANKS  = 1 << BANK_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_we,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic                 cfg_muxed,
    input  logic [SAS_SET_W-1:0] cfg_addr_setup,
    input  logic [SAS_SET_W-1:0] cfg_addr_hold,
    input  logic [SAS_DST_W-1:0] cfg_data_setup,
    input  logic [SAS_SET_W-1:0] cfg_addr_turnaround,
    output logic [BANKS-1:0]     mem_cs_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [WIN_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]    mem_dq_out,
    output logic                 mem_dq_oe,
    input  logic [DATA_W-1:0]    mem_dq_in,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata
);

    // ------------------------------------------------------------------
    // Captured request and timing
    // ------------------------------------------------------------------
    sas_state_e           state_q;
    sas_state_e           state_d;
    sas_timing_t          cfg_live;
    sas_timing_t          cfg_q;
    sas_timing_t          cfg_eff;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    wdata_q;
    logic                 we_q;
    logic                 accept;
    logic                 phase_done;
    logic                 timer_load;
    logic [SAS_CNT_W-1:0] timer_val;
    logic                 access_on;
    logic                 addr_phase;
    logic                 data_last;
    logic [SAS_DST_W-1:0] data_len_m1;

    sas_cfg_clamp i_cfg_clamp (
        .muxed      (cfg_muxed),
        .addr_setup (cfg_addr_setup),
        .addr_hold  (cfg_addr_hold),
        .data_setup (cfg_data_setup),
        .turnaround (cfg_addr_turnaround),
        .timing     (cfg_live)
    );

    assign accept  = req_valid && (state_q == ST_IDLE);
    assign cfg_eff = (state_q == ST_IDLE) ? cfg_live : cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
        end else if (accept) begin
            cfg_q   <= cfg_live;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            we_q    <= req_we;
        end
    end

    // ------------------------------------------------------------------
    // Next-state logic
    // ------------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cfg_eff.setup_len != '0) begin
                        state_d = ST_ADDR_SETUP;
                    end else if (cfg_eff.muxed) begin
                        state_d = ST_ADDR_HOLD;
                    end else begin
                        state_d = ST_DATA_SETUP;
                    end
                end
            end
            ST_ADDR_SETUP: begin
                if (phase_done) begin
                    state_d = cfg_eff.muxed ? ST_ADDR_HOLD : ST_DATA_SETUP;
                end
            end
            ST_ADDR_HOLD: begin
                if (phase_done) begin
                    state_d = ST_DATA_SETUP;
                end
            end
            ST_DATA_SETUP: begin
                if (phase_done) begin
                    if (we_q) begin
                        state_d = ST_WRITE_RECOV;
                    end else if (cfg_eff.turn_len != '0) begin
                        state_d = ST_TURNAROUND;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_WRITE_RECOV: begin
                if (phase_done) begin
                    state_d = (cfg_eff.turn_len != '0) ? ST_TURNAROUND : ST_IDLE;
                end
            end
            ST_TURNAROUND: begin
                if (phase_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ------------------------------------------------------------------
    // State register
    // ------------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ------------------------------------------------------------------
    // Phase timer: loaded with length-1 on every state change
    // ------------------------------------------------------------------
    assign timer_load  = (state_d != state_q);
    assign data_len_m1 = cfg_eff.data_len - SAS_DST_W'(1);

    always_comb begin
        unique case (state_d)
            ST_ADDR_SETUP: timer_val = SAS_CNT_W'(cfg_eff.setup_len) - SAS_CNT_W'(1);
            ST_ADDR_HOLD:  timer_val = SAS_CNT_W'(cfg_eff.hold_len) - SAS_CNT_W'(1);
            ST_DATA_SETUP: timer_val = data_len_m1[SAS_CNT_W-1:0];
            ST_TURNAROUND: timer_val = SAS_CNT_W'(cfg_eff.turn_len) - SAS_CNT_W'(1);
            default:       timer_val = '0;
        endcase
    end

    sas_phase_timer #(
        .CNT_W (SAS_CNT_W)
    ) i_phase_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .expired  (phase_done)
    );

    // ------------------------------------------------------------------
    // Pin outputs, decoded from state
    // ------------------------------------------------------------------
    always_comb begin
        access_on  = 1'b0;
        addr_phase = 1'b0;
        mem_oe_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        req_ready  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_ADDR_SETUP, ST_ADDR_HOLD: begin
                access_on  = 1'b1;
                addr_phase = 1'b1;
                mem_dq_oe  = cfg_q.muxed;
            end
            ST_DATA_SETUP: begin
                access_on = 1'b1;
                mem_oe_n  = we_q;
                mem_we_n  = !we_q;
                mem_dq_oe = we_q;
            end
            ST_WRITE_RECOV: begin
                access_on = 1'b1;
                mem_dq_oe = 1'b1;
            end
            ST_TURNAROUND: begin
                access_on = 1'b0;
            end
            default: begin
                access_on = 1'b0;
            end
        endcase
    end

    assign mem_addr   = addr_q[WIN_W-1:0];
    assign mem_dq_out = addr_phase ? addr_q[DATA_W-1:0] : wdata_q;

    sas_bank_decode #(
        .ADDR_W (ADDR_W),
        .WIN_W  (WIN_W)
    ) i_bank_decode (
        .enable (access_on),
        .addr   (addr_q),
        .cs_n   (mem_cs_n)
    );

    // ------------------------------------------------------------------
    // Completion: sample read data on the last data setup cycle
    // ------------------------------------------------------------------
    assign data_last = (state_q == ST_DATA_SETUP) && phase_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= data_last;
            if (data_last) begin
                rdata <= mem_dq_in;
            end
        end
    end

endmodule

// File: rtl/sas_async_seq_chk.sv
module sas_async_seq_chk #(
    parameter int BANKS  = 4,
    parameter int WIN_W  = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic [BANKS-1:0] mem_cs_n,
    input logic             mem_oe_n,
    input logic             mem_we_n,
    input logic [WIN_W-1:0] mem_addr,
    input logic             mem_dq_oe,
    input logic             done
);

    logic cs_any;
    assign cs_any = |(~mem_cs_n);

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n)); // R11

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R11

    AST_WE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> cs_any); // R8

    AST_WE_RELEASE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> cs_any); // R8

    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cs_any)); // R7

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cs_any |-> !req_ready); // R10

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_any && $past(cs_any)) |-> ($stable(mem_addr) && $stable(mem_cs_n))); // R3

endmodule

bind sas_async_seq sas_async_seq_chk #(
    .BANKS (BANKS),
    .WIN_W (WIN_W)
) i_sas_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe),
    .done      (done)
);

// File: tb/test_sas_async_seq.sv
module test_sas_async_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 28;
    localparam int WIN_W  = 26;
    localparam int DATA_W = 16;
    localparam int BANKS  = 1 << (ADDR_W - WIN_W);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              cfg_muxed = 1'b0;
    logic [3:0]        cfg_addr_setup = '0;
    logic [3:0]        cfg_addr_hold = '0;
    logic [8:0]        cfg_data_setup = '0;
    logic [3:0]        cfg_addr_turnaround = '0;
    logic [BANKS-1:0]  mem_cs_n;
    logic              mem_oe_n;
    logic              mem_we_n;
    logic [WIN_W-1:0]  mem_addr;
    logic [DATA_W-1:0] mem_dq_out;
    logic              mem_dq_oe;
    logic [DATA_W-1:0] mem_dq_in = '0;
    logic              done;
    logic [DATA_W-1:0] rdata;

    int n_vec = 0;
    int n_err = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sas_async_seq #(
        .ADDR_W (ADDR_W),
        .WIN_W  (WIN_W),
        .DATA_W (DATA_W)
    ) i_sas_async_seq (
        .clk                 (clk),
        .rst_n               (rst_n),
        .req_valid           (req_valid),
        .req_ready           (req_ready),
        .req_we              (req_we),
        .req_addr            (req_addr),
        .req_wdata           (req_wdata),
        .cfg_muxed           (cfg_muxed),
        .cfg_addr_setup      (cfg_addr_setup),
        .cfg_addr_hold       (cfg_addr_hold),
        .cfg_data_setup      (cfg_data_setup),
        .cfg_addr_turnaround (cfg_addr_turnaround),
        .mem_cs_n            (mem_cs_n),
        .mem_oe_n            (mem_oe_n),
        .mem_we_n            (mem_we_n),
        .mem_addr            (mem_addr),
        .mem_dq_out          (mem_dq_out),
        .mem_dq_oe           (mem_dq_oe),
        .mem_dq_in           (mem_dq_in),
        .done                (done),
        .rdata               (rdata)
    );

    function automatic int exp_data_len(input logic [8:0] ds);
        if (ds == 0) return 1;
        if (ds > 256) return 256;
        return int'(ds);
    endfunction

    function automatic int exp_hold_len(input logic mx, input logic [3:0] ah);
        if (!mx) return 0;
        return (ah == 0) ? 1 : int'(ah);
    endfunction

    function automatic logic [BANKS-1:0] exp_cs(input logic on, input logic [ADDR_W-1:0] a);
        if (!on) return '1;
        return ~(BANKS'(1) << a[ADDR_W-1:WIN_W]);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive_junk(input logic vld);
        req_valid           = vld;
        req_we              = 1'($urandom);
        req_addr            = ADDR_W'($urandom);
        req_wdata           = DATA_W'($urandom);
        cfg_muxed           = 1'($urandom);
        cfg_addr_setup      = 4'($urandom);
        cfg_addr_hold       = 4'($urandom);
        cfg_data_setup      = 9'($urandom);
        cfg_addr_turnaround = 4'($urandom);
    endtask

    // One full access: accept, then compare every cycle until idle again.
    task automatic do_access(input logic [ADDR_W-1:0] a, input logic w,
                             input logic [DATA_W-1:0] wd, input logic mx,
                             input logic [3:0] as, input logic [3:0] ah,
                             input logic [8:0] ds, input logic [3:0] bt);
        int na, nh, nd, nw, nt, total, k;
        logic [DATA_W-1:0] exp_rd;
        na = int'(as);
        nh = exp_hold_len(mx, ah);
        nd = exp_data_len(ds);
        nw = w ? 1 : 0;
        nt = int'(bt);
        total = na + nh + nd + nw + nt;
        exp_rd = '0;

        check("R10 ready before accept", 64'(req_ready), 64'(1));
        check("R1/R9 strobes idle", 64'(mem_cs_n), 64'(exp_cs(1'b0, a)));
        req_valid = 1'b1; req_we = w; req_addr = a; req_wdata = wd;
        cfg_muxed = mx; cfg_addr_setup = as; cfg_addr_hold = ah;
        cfg_data_setup = ds; cfg_addr_turnaround = bt;
        @(negedge clk);
        for (k = 1; k <= total + 1; k++) begin
            logic in_as, in_ah, in_ds, in_wr, on;
            drive_junk(k <= total);
            mem_dq_in = DATA_W'($urandom);
            if (k == na + nh + nd) exp_rd = mem_dq_in;
            #1;
            in_as = (k <= na);
            in_ah = (k > na) && (k <= na + nh);
            in_ds = (k > na + nh) && (k <= na + nh + nd);
            in_wr = (k > na + nh + nd) && (k <= na + nh + nd + nw);
            on    = in_as || in_ah || in_ds || in_wr;
            check("R3 chip select", 64'(mem_cs_n), 64'(exp_cs(on, a)));
            if (on) check("R3 window offset", 64'(mem_addr), 64'(a[WIN_W-1:0]));
            check("R7 oe_n", 64'(mem_oe_n), 64'(!(in_ds && !w)));
            check("R8 we_n", 64'(mem_we_n), 64'(!(in_ds && w)));
            check("R5 dq_oe", 64'(mem_dq_oe), 64'((mx && (in_as || in_ah)) || (w && (in_ds || in_wr))));
            if (mx && (in_as || in_ah))
                check("R5 muxed address", 64'(mem_dq_out), 64'(a[DATA_W-1:0]));
            if (w && (in_ds || in_wr))
                check("R8 write data", 64'(mem_dq_out), 64'(wd));
            check("R10 ready while busy", 64'(req_ready), 64'(k > total));
            check("R7 done timing", 64'(done), 64'(k == na + nh + nd + 1));
            if (k == na + nh + nd + 1 && !w)
                check("R7 read data", 64'(rdata), 64'(exp_rd));
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ready", 64'(req_ready), 64'(1));
        check("R1 cs_n", 64'(mem_cs_n), 64'({BANKS{1'b1}}));
        check("R1 oe_n", 64'(mem_oe_n), 64'(1));
        check("R1 we_n", 64'(mem_we_n), 64'(1));
        check("R1 dq_oe", 64'(mem_dq_oe), 64'(0));
        check("R1 done", 64'(done), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after release", 64'(req_ready), 64'(1));

        // Directed corner cases
        do_access(28'h0012345, 1'b0, 16'h0000, 1'b0, 4'd0,  4'd0,  9'd0,   4'd0);  // R4 skip, R6 0->1
        do_access(28'h4ABCDEF, 1'b1, 16'hBEEF, 1'b1, 4'd2,  4'd0,  9'd300, 4'd15); // R5 0->1, R6 >256
        do_access(28'h8765432, 1'b0, 16'h0000, 1'b1, 4'd15, 4'd15, 9'd256, 4'd15); // R4/R5/R6 maxima
        do_access(28'hC000001, 1'b1, 16'h1234, 1'b0, 4'd0,  4'd7,  9'd1,   4'd0);  // R8 minimum write
        do_access(28'hFFFFFFF, 1'b0, 16'h0000, 1'b1, 4'd0,  4'd3,  9'd511, 4'd1);  // R6 top clamp
        do_access(28'h3FFFFFF, 1'b1, 16'hA5A5, 1'b0, 4'd1,  4'd9,  9'd2,   4'd0);  // R9 zero gap

        // Constrained random accesses, R2 via junk inputs while busy
        for (int i = 0; i < 150; i++) begin
            logic [8:0] ds;
            ds = (($urandom % 8) == 0) ? 9'($urandom) : 9'($urandom % 24);
            do_access(ADDR_W'($urandom), 1'($urandom), DATA_W'($urandom), 1'($urandom),
                      4'($urandom), 4'($urandom), ds, 4'($urandom));
        end

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL R10 watchdog: actual hung expected idle");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

endmodule